// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block is the sending side of a synchronous serial link. Words are written into a small internal queue. The block then sends them one after another on a single data line, together with a serial clock and an optional frame sync. The serial clock is made by dividing the system clock. Each word can be 3 to 32 bits long and can be sent starting from either end.

The frame sync can be turned off for a plain continuous stream. When it is on, its polarity can be chosen, and it can mark either the first bit of a word or the bit slot just before it. An optional G.711 compander, µ-law or A-law, turns a 16-bit linear sample into an 8-bit code. It sits directly in front of the shifter, so a compressed word goes out in the same slot an uncompressed word would. When a word is due and the queue is empty, the last word is sent again and an underflow indication is raised.

All configuration inputs are meant to stay static while the block runs. Change them only while reset is asserted.

Top module: `serial_frame_tx`

## Requirements
- R1: The queue holds 8 words, and `full` is high whenever 8 are held. A write made while `full` is high is dropped, and that word is never sent.
- R2: After reset `sclk`, `sdata` and `underflow` are 0. `sclk` has a period of 2×(`clkDiv`+1) system clocks. `sdata` changes only in the cycle in which `sclk` goes high.
- R3: A word is `wordLenM1`+1 bits long, and settings below 2 send 3-bit words. Words follow each other with no gap; the first word is fetched at the first `sclk` rise after reset.
- R4: With `lsbFirst`=0 the bits go out from bit `wordLenM1` down to bit 0. With `lsbFirst`=1 they go out from bit 0 upward.
- R5: With `fsLate`=1 the frame sync is active for exactly the `sclk` period that carries bit slot 0 of every word.
- R6: With `fsLate`=0 the frame sync is active for the `sclk` period that carries the last bit of the previous word. The first word after reset therefore has no frame sync.
- R7: The active level of `fsync` is high when `fsActiveLow`=0 and low when it is 1. With `fsEnable`=0, `fsync` stays at its inactive level.
- R8: `compMode`=1 selects µ-law and `compMode`=2 selects A-law (G.711). The code is taken from `wrData[15:0]` read as a signed sample. The word length is then forced to 8, and the 8-bit code is sent in the chosen bit order, starting in the same slot as an uncompressed word. Values 0 and 3 send the written data unchanged.
- R9: If the queue is empty when a word is due, the previous word is sent again. `underflow` is high for the whole of that word. A repeat right after reset sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the queue |
| wrData | input | 32 | Word to queue |
| clkDiv | input | 16 | Serial clock divider |
| wordLenM1 | input | 5 | Word length minus one |
| lsbFirst | input | 1 | Send least significant bit first |
| fsEnable | input | 1 | Enable frame sync |
| fsLate | input | 1 | 1: sync with first bit, 0: one slot ahead |
| fsActiveLow | input | 1 | Frame sync active level is low |
| compMode | input | 2 | 0/3 none, 1 µ-law, 2 A-law |
| full | output | 1 | Queue holds 8 words |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| fsync | output | 1 | Frame sync |
| underflow | output | 1 | Current word is a repeat |

## Verification
`sdata`, `fsync` and `underflow` all change at the system clock edge where `sclk` rises, and at no other time. `full` reflects a write or a fetch one edge after it happens, so a word written in one cycle can be fetched at the next `sclk` rise. The bench keeps a behavioural model made of a word queue and integer counters. It steps this model at each rising edge and compares every output on the following falling edge, so each result is checked in the exact cycle it becomes due.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef struct packed {
    logic load;   // fetch a new word and present its first bit
    logic shift;  // present the next bit of the current word
  } txStrobe_t;

  // G.711 mu-law from a 14-bit signed sample (linear >> 2)
  function automatic logic [7:0] muEncode(input logic [13:0] p);
    logic        neg;
    logic [13:0] mag;
    logic [13:0] sh;
    logic [3:0]  seg;
    logic [7:0]  raw;
    neg = p[13];
    mag = neg ? (~p + 14'd1) : p;
    if (mag > 14'd8159) mag = 14'd8159;
    mag = mag + 14'd33;
    seg = 4'd0;
    for (int i = 6; i < 14; i++) begin
      if (mag[i]) seg = 4'(i - 5);
    end
    sh  = mag >> (seg + 4'd1);
    raw = (seg >= 4'd8) ? 8'h7F : {1'b0, seg[2:0], sh[3:0]};
    return raw ^ (neg ? 8'h7F : 8'hFF);
  endfunction

  // G.711 A-law from a 13-bit signed sample (linear >> 3)
  function automatic logic [7:0] aEncode(input logic [12:0] m13);
    logic        neg;
    logic [11:0] m;
    logic [11:0] sh;
    logic [3:0]  seg;
    neg = m13[12];
    m   = neg ? ~m13[11:0] : m13[11:0];
    seg = 4'd0;
    for (int i = 5; i < 12; i++) begin
      if (m[i]) seg = 4'(i - 4);
    end
    sh = (seg < 4'd2) ? (m >> 1) : (m >> seg);
    return {1'b0, seg[2:0], sh[3:0]} ^ (neg ? 8'h55 : 8'hD5);
  endfunction

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [IDX_W-1:0] wordLenM1,
  input  logic             compOn,
  input  logic             fsEnable,
  input  logic             fsLate,
  input  logic             fsActiveLow,
  output logic             sclk,
  output logic             fsync,
  output txStrobe_t        strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic [IDX_W-1:0] lenM1
);

  localparam logic [IDX_W-1:0] MinLenM1  = IDX_W'(2);
  localparam logic [IDX_W-1:0] CompLenM1 = IDX_W'(7);

  logic [DIV_W-1:0] divCnt;
  logic             sclkQ;
  logic             started;
  logic             fsOnQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] lenM1Eff;
  logic             halfTick;
  logic             rise;
  logic             doLoad;

  always_comb begin
    if (compOn)                     lenM1Eff = CompLenM1;
    else if (wordLenM1 < MinLenM1)  lenM1Eff = MinLenM1;
    else                            lenM1Eff = wordLenM1;
    halfTick = (divCnt == clkDiv);
    rise     = halfTick && !sclkQ;
    doLoad   = rise && (!started || (bitIdxQ == lenM1Eff));
    nextIdx  = doLoad ? '0 : bitIdxQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkQ   <= 1'b0;
      started <= 1'b0;
      bitIdxQ <= '0;
      fsOnQ   <= 1'b0;
    end else begin
      divCnt <= halfTick ? '0 : divCnt + 1'b1;
      if (halfTick) sclkQ <= ~sclkQ;
      if (rise) begin
        bitIdxQ <= nextIdx;
        started <= 1'b1;
        fsOnQ   <= fsEnable && (fsLate ? doLoad : (nextIdx == lenM1Eff));
      end
    end
  end

  assign strb.load  = doLoad;
  assign strb.shift = rise && !doLoad;
  assign bitIdx     = nextIdx;
  assign lenM1      = lenM1Eff;
  assign sclk       = sclkQ;
  assign fsync      = fsOnQ ^ fsActiveLow;

endmodule

// File: rtl/sftx_dp.sv
module sftx_dp
  import sftx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              compOn,
  input  logic              useAlaw,
  input  logic              lsbFirst,
  input  txStrobe_t         strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [IDX_W-1:0]  lenM1,
  output logic              full,
  output logic              sdata,
  output logic              underflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LastPtr  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FullCnt  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              empty, push, pop;
  logic [DATA_W-1:0] head, packedWord, loadWord, curWord;
  logic [7:0]        code;
  logic [IDX_W-1:0]  sel;
  logic              sdataQ, underflowQ;

  always_comb begin
    full       = (count == FullCnt);
    empty      = (count == '0);
    push       = wrEn && !full;
    pop        = strb.load && !empty;
    head       = mem[rdPtr];
    code       = useAlaw ? aEncode(head[15:3]) : muEncode(head[15:2]);
    packedWord = compOn ? DATA_W'(code) : head;
    loadWord   = empty ? curWord : packedWord;
    sel        = lsbFirst ? bitIdx : (lenM1 - bitIdx);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      curWord    <= '0;
      sdataQ     <= 1'b0;
      underflowQ <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == LastPtr) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LastPtr) ? '0 : rdPtr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
      if (strb.load) begin
        curWord    <= loadWord;
        sdataQ     <= loadWord[sel];
        underflowQ <= empty;
      end else if (strb.shift) begin
        sdataQ <= curWord[sel];
      end
    end
  end

  assign sdata     = sdataQ;
  assign underflow = underflowQ;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 8,
  parameter  int DIV_W  = 16,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [IDX_W-1:0]  wordLenM1,
  input  logic              lsbFirst,
  input  logic              fsEnable,
  input  logic              fsLate,
  input  logic              fsActiveLow,
  input  logic [1:0]        compMode,
  output logic              full,
  output logic              sclk,
  output logic              sdata,
  output logic              fsync,
  output logic              underflow
);

  txStrobe_t        strb;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lenM1;
  logic             compOn;
  logic             useAlaw;

  assign compOn  = (compMode == 2'd1) || (compMode == 2'd2);
  assign useAlaw = (compMode == 2'd2);

  sftx_ctrl #(.DIV_W(DIV_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .wordLenM1(wordLenM1),
    .compOn(compOn), .fsEnable(fsEnable), .fsLate(fsLate),
    .fsActiveLow(fsActiveLow), .sclk(sclk), .fsync(fsync),
    .strb(strb), .bitIdx(bitIdx), .lenM1(lenM1)
  );

  sftx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .compOn(compOn), .useAlaw(useAlaw), .lsbFirst(lsbFirst),
    .strb(strb), .bitIdx(bitIdx), .lenM1(lenM1),
    .full(full), .sdata(sdata), .underflow(underflow)
  );

endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic sdata,
  input logic fsync,
  input logic underflow,
  input logic full
);

  assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdata) |-> $rose(sclk));

  assert_fsync_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fsync) |-> $rose(sclk));

  assert_uflow_on_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(underflow) |-> $rose(sclk));

  assert_full_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(full) |-> $rose(sclk));

endmodule

bind serial_frame_tx sftx_checker uChk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .sdata(sdata),
  .fsync(fsync), .underflow(underflow), .full(full)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [15:0] clkDiv = 16'd1;
  logic [4:0]  wordLenM1 = 5'd7;
  logic        lsbFirst = 1'b0;
  logic        fsEnable = 1'b1;
  logic        fsLate = 1'b1;
  logic        fsActiveLow = 1'b0;
  logic [1:0]  compMode = 2'd0;
  logic        full, sclk, sdata, fsync, underflow;

  always #2 clk = ~clk;

  serial_frame_tx u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .clkDiv(clkDiv),
    .wordLenM1(wordLenM1), .lsbFirst(lsbFirst), .fsEnable(fsEnable),
    .fsLate(fsLate), .fsActiveLow(fsActiveLow), .compMode(compMode),
    .full(full), .sclk(sclk), .sdata(sdata), .fsync(fsync), .underflow(underflow)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "";

  // behavioural reference state
  int          mDiv, mIdx;
  bit          mSclk, mStarted, mSd, mUf, mFs;
  logic [31:0] mCur;
  logic [31:0] mQ[$];
  logic [31:0] pend[$];

  function automatic int muRef(int x);
    int p, mag, mask, seg, lim;
    p = x >>> 2;
    if (p < 0) begin mag = -p; mask = 127; end else begin mag = p; mask = 255; end
    if (mag > 8159) mag = 8159;
    mag = mag + 33;
    seg = 0; lim = 63;
    while (seg < 8 && mag > lim) begin seg++; lim = lim * 2 + 1; end
    if (seg >= 8) return 127 ^ mask;
    return (seg * 16 + ((mag >> (seg + 1)) % 16)) ^ mask;
  endfunction

  function automatic int aRef(int x);
    int m, mask, seg, lim, mant;
    m = x >>> 3;
    if (m < 0) begin m = -m - 1; mask = 85; end else mask = 213;
    seg = 0; lim = 31;
    while (seg < 8 && m > lim) begin seg++; lim = lim * 2 + 1; end
    mant = (seg < 2) ? ((m / 2) % 16) : ((m >> seg) % 16);
    return (seg * 16 + mant) ^ mask;
  endfunction

  function automatic int lenM1Ref();
    if (compMode == 2'd1 || compMode == 2'd2) return 7;
    if (wordLenM1 < 5'd2) return 2;
    return int'(wordLenM1);
  endfunction

  task automatic check1(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, cyc, got, exp);
    end
  endtask

  task automatic compareAll();
    check1("sclk", sclk, mSclk);
    check1("sdata", sdata, mSd);
    check1("fsync", fsync, mFs ^ fsActiveLow);
    check1("underflow", underflow, mUf);
    check1("full", full, mQ.size() == 8);
  endtask

  task automatic modelStep();
    bit rise, acc, ld;
    int lm, k, xs;
    logic [31:0] w;
    rise = (mDiv == int'(clkDiv)) && !mSclk;
    acc  = wrEn && (mQ.size() < 8);
    if (rise) begin
      lm = lenM1Ref();
      ld = 1'b0;
      if (!mStarted || mIdx == lm) begin
        ld = 1'b1;
        if (mQ.size() > 0) begin
          w   = mQ.pop_front();
          mUf = 1'b0;
          xs  = int'($signed(w[15:0]));
          if (compMode == 2'd1)      mCur = 32'(muRef(xs));
          else if (compMode == 2'd2) mCur = 32'(aRef(xs));
          else                       mCur = w;
        end else begin
          mUf = 1'b1;
        end
        mIdx = 0;
        mStarted = 1'b1;
      end else begin
        mIdx++;
      end
      k   = lsbFirst ? mIdx : (lm - mIdx);
      mSd = mCur[k];
      mFs = fsEnable && (fsLate ? ld : (mIdx == lm));
    end
    if (acc) mQ.push_back(wrData);
    if (mDiv == int'(clkDiv)) begin mDiv = 0; mSclk = !mSclk; end
    else mDiv++;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wrEn = 1'b0;
    mDiv = 0; mIdx = 0; mSclk = 0; mStarted = 0; mSd = 0; mUf = 0; mFs = 0;
    mCur = '0;
    mQ.delete();
    pend.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state, R2
    check1("reset sclk R2", sclk, 1'b0);
    check1("reset sdata R2", sdata, 1'b0);
    check1("reset underflow R2", underflow, 1'b0);
    check1("reset full R1", full, 1'b0);
    check1("reset fsync R7", fsync, fsActiveLow);
    rstN = 1'b1;
    @(posedge clk);
    modelStep();
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      compareAll();
      if (pend.size() > 0) begin wrEn = 1'b1; wrData = pend.pop_front(); end
      else wrEn = 1'b0;
      @(posedge clk);
      modelStep();
    end
  endtask

  task automatic setCfg(int dv, int wl, bit lsb, bit fe, bit late, bit low, int cm);
    clkDiv = 16'(dv); wordLenM1 = 5'(wl); lsbFirst = lsb; fsEnable = fe;
    fsLate = late; fsActiveLow = low; compMode = 2'(cm);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 R3 R5: 8-bit msb-first, late active-high sync
    tag = "R2 R3 R5 R4";
    setCfg(1, 7, 0, 1, 1, 0, 0);
    doReset();
    pend = '{32'hA5, 32'h3C, 32'hF0, 32'h81};
    run(400);

    // R4 R6: 32-bit lsb-first, early sync, fastest clock
    tag = "R4 R6 R3";
    setCfg(0, 31, 1, 1, 0, 0, 0);
    doReset();
    pend = '{32'hDEADBEEF, 32'h12345678, 32'h80000001};
    run(300);

    // R3 R7: length clamped to 3, active-low sync
    tag = "R3 R7";
    setCfg(2, 0, 0, 1, 1, 1, 0);
    doReset();
    pend = '{32'h5, 32'h2, 32'h7, 32'h1, 32'h6};
    run(300);

    // R7: sync disabled, inactive level held
    tag = "R7 R3";
    setCfg(0, 11, 0, 0, 1, 1, 0);
    doReset();
    pend = '{32'hABC, 32'h123};
    run(150);

    // R8: mu-law with extremes and signs
    tag = "R8 mu-law";
    setCfg(0, 20, 0, 1, 1, 0, 1);
    doReset();
    pend = '{32'h0, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h1234, 32'hE000, 32'h0100};
    run(250);

    // R8: A-law, lsb first, early sync
    tag = "R8 A-law R4";
    setCfg(0, 3, 1, 1, 0, 0, 2);
    doReset();
    pend = '{32'h0, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h1234, 32'hE000, 32'h0100};
    run(250);

    // R1: overflow of the queue, dropped writes
    tag = "R1";
    setCfg(3, 7, 0, 1, 1, 0, 0);
    doReset();
    for (int i = 0; i < 12; i++) pend.push_back(32'(8'h11 * (i + 1)));
    run(900);

    // R9: underflow repeats the last word
    tag = "R9";
    setCfg(0, 4, 0, 1, 1, 0, 3);
    doReset();
    pend = '{32'h15, 32'h0A};
    run(200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule